// File: doc/BRIEF.md
# I2C Bus Master, Transmit Direction, with Event Status Codes

This block is a command-stepped I2C master for the transmit direction. A host loads a byte into a data register and writes a control word that holds an enable bit, a start-request bit, a stop-request bit and a go bit. The go bit clears the completion flag and releases the next bus action. The block drives open-drain SCL and SDA through active-high pull-down enables. It reads the real line levels back to sample the acknowledge bit, to detect lost arbitration and to track whether the bus is busy.

Each completed bus event raises the completion flag and places an 8-bit status code in the status output. The block then waits for the host. While the flag is set the block holds SCL low, so the bus stays stalled until the host decides on the next step. The host can send a byte, issue a repeated START, issue a STOP, or issue a STOP followed directly by a new START. If an address byte with its read bit set has been sent, the block hands the bus to a receive path outside this block and takes no further transmit action. SCL timing comes from a programmable phase divider.

Top module: `i2cm_tx_master`

## Requirements
- R1: After reset, and whenever the enable bit is 0, both line enables are 0, the flag is 0 and the status reads 0xF8. After reset the bus-busy output is also 0.
- R2: A go write with the start bit set from idle sends a START once the bus is free and reports 0x08. The same command issued after a transfer sends a repeated START and reports 0x10.
- R3: The first byte after any START is the address. It is shifted out most significant bit first. If its bit 0 is 0, the block reports 0x18 when ACK (SDA low in the ninth clock) was sampled and 0x20 when NACK was sampled.
- R4: Any later byte is a data byte. The block reports 0x28 on ACK and 0x30 on NACK.
- R5: The flag rises together with each new status code. While the flag is set and the code is not 0x38, SCL is pulled low. While the flag is clear, the status reads 0xF8.
- R6: On a go write after a transfer, the start and stop bits select the action. 0/0 sends the loaded byte, 1/0 sends a repeated START, 0/1 sends a STOP, and 1/1 sends a STOP followed by a START.
- R7: The stop-request output stays 1 from the command until the STOP condition has been placed on the lines, then clears by itself. A STOP raises no flag and leaves the status at 0xF8.
- R8: If the block releases SDA for a 1 bit of an address or data byte and reads SDA low while SCL is high, it releases both lines at once and reports 0x38.
- R9: After 0x38, a go write with the start bit clear returns the block to idle with both lines released. With the start bit set, the block waits until the bus is free and then sends a START that reports 0x08.
- R10: The bus-busy output rises after any START seen on the lines, including one from another master. It falls after a STOP.
- R11: After an address byte with bit 0 set has been acknowledged, the rx-handoff output goes to 1. The flag stays 0, the status reads 0xF8 and SCL stays low. In this state every command except one with the stop bit set is ignored.
- R12: Each SCL phase lasts div_cfg+1 clock cycles, so an unstretched SCL high period is 2*(div_cfg+1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_en | input | 1 | Enable bit |
| ctl_sta | input | 1 | Start-request bit |
| ctl_sto | input | 1 | Stop-request bit |
| ctl_go | input | 1 | Clear flag and launch the next action |
| dat_wr | input | 1 | Data register write strobe |
| dat_in | input | 8 | Address or data byte |
| div_cfg | input | DIVW | SCL phase length minus one, in clocks |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| status | output | 8 | Event status code |
| flag | output | 1 | Completion flag |
| stop_pend | output | 1 | Stop request still pending |
| bus_busy | output | 1 | Bus held by some master |
| rx_handoff | output | 1 | Read address sent, receive path owns the bus |

## Verification
The assertions check on every cycle that the flag and the status code agree and that SCL is held low behind a set flag. They also check that a lost arbitration leaves both lines released, that the stop request drops only once both lines are free, that a START on the lines marks the bus busy, and that the handoff state raises no flag. Only the bench scenarios can show the event ordering. This covers the exact code after each kind of acknowledge, the byte order on SDA, and the command decode of the four actions. It also covers the START held back until a foreign master's STOP, the ignored commands during handoff, and the SCL high time set by the divider.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NACK = 8'h20;
  localparam logic [7:0] ST_D_ACK   = 8'h28;
  localparam logic [7:0] ST_D_NACK  = 8'h30;
  localparam logic [7:0] ST_ARB     = 8'h38;
  localparam logic [7:0] ST_NONE    = 8'hF8;

  typedef enum logic [2:0] {
    S_IDLE, S_WFREE, S_START, S_BYTE, S_HOLD, S_STOP, S_LOST, S_RXH
  } mst_state_e;

  typedef struct packed {
    mst_state_e  st;
    logic [1:0]  ph;
    logic [3:0]  bitn;
    logic [7:0]  sh;
    logic [7:0]  stat;
    logic        flag;
    logic        sta;
    logic        sto;
    logic        addr;
    logic        rep;
    logic        rd;
    logic        ack;
    logic        scl;
    logic        sda;
  } mst_ctx_t;

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);

  logic [DIVW-1:0] cnt_q;
  logic [DIVW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)               cnt_d = '0;
    else if (cnt_q == '0)   cnt_d = div;
    else                    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run && (cnt_q == '0);

endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic busy
);

  logic scl_q;
  logic sda_q;
  logic busy_q;
  logic busy_d;
  logic st_seen;
  logic sp_seen;

  assign st_seen = scl && scl_q && sda_q && !sda;
  assign sp_seen = scl && scl_q && !sda_q && sda;

  always_comb begin
    busy_d = busy_q;
    if (st_seen)      busy_d = 1'b1;
    else if (sp_seen) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_q  <= scl;
      sda_q  <= sda;
      busy_q <= busy_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/i2cm_tx_master.sv
module i2cm_tx_master
  import i2cm_pkg::*;
#(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_wr,
  input  logic            ctl_en,
  input  logic            ctl_sta,
  input  logic            ctl_sto,
  input  logic            ctl_go,
  input  logic            dat_wr,
  input  logic [7:0]      dat_in,
  input  logic [DIVW-1:0] div_cfg,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            scl_oe,
  output logic            sda_oe,
  output logic [7:0]      status,
  output logic            flag,
  output logic            stop_pend,
  output logic            bus_busy,
  output logic            rx_handoff
);

  localparam logic [3:0] ACK_SLOT = 4'd8;

  logic [1:0] rs_q;
  logic       rst_i;
  logic       en_q;
  logic [7:0] dat_q;
  logic       tick;
  logic       adv;
  logic       go;
  mst_ctx_t   q;
  mst_ctx_t   d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  i2cm_tick #(.DIVW(DIVW)) u_tick (
    .clk (clk), .rst_n (rst_i), .run (en_q), .div (div_cfg), .tick (tick)
  );

  i2cm_busmon u_busmon (
    .clk (clk), .rst_n (rst_i), .scl (scl_in), .sda (sda_in), .busy (bus_busy)
  );

  assign go  = ctl_wr && ctl_go;
  // the high phase waits for SCL to be seen high (clock stretching)
  assign adv = tick && !(q.ph == 2'd2 && !scl_in);

  always_comb begin
    d = q;
    if (ctl_wr) begin
      d.sta = ctl_sta;
      d.sto = ctl_sto;
    end
    if (go) begin
      d.flag = 1'b0;
      d.stat = ST_NONE;
    end
    unique case (q.st)
      S_IDLE: begin
        d.scl = 1'b0;
        d.sda = 1'b0;
        if (go && ctl_sta) d.st = S_WFREE;
      end
      S_WFREE: begin
        if (tick && !bus_busy) begin
          d.st  = S_START;
          d.ph  = 2'd0;
          d.rep = 1'b0;
        end
      end
      S_LOST: begin
        if (go) d.st = ctl_sta ? S_WFREE : S_IDLE;
      end
      S_HOLD: begin
        if (go) begin
          d.ph = 2'd0;
          if (ctl_sto) begin
            d.st = S_STOP;
          end else if (ctl_sta) begin
            d.st  = S_START;
            d.rep = 1'b1;
          end else begin
            d.st   = S_BYTE;
            d.sh   = dat_q;
            d.bitn = 4'd0;
            d.rd   = q.addr && dat_q[0];
          end
        end
      end
      S_RXH: begin
        if (go && ctl_sto) begin
          d.st = S_STOP;
          d.ph = 2'd0;
        end
      end
      S_START: begin
        if (adv) begin
          d.ph = q.ph + 2'd1;
          unique case (q.ph)
            2'd0: d.sda = 1'b0;
            2'd1: d.scl = 1'b0;
            2'd2: d.sda = 1'b1;
            2'd3: begin
              d.scl  = 1'b1;
              d.st   = S_HOLD;
              d.flag = 1'b1;
              d.stat = q.rep ? ST_RSTART : ST_START;
              d.addr = 1'b1;
              d.sta  = 1'b0;
            end
          endcase
        end
      end
      S_STOP: begin
        if (adv) begin
          d.ph = q.ph + 2'd1;
          unique case (q.ph)
            2'd0: d.sda = 1'b1;
            2'd1: d.scl = 1'b0;
            2'd2: begin
              d.sda = 1'b0;
              d.sto = 1'b0;
            end
            2'd3: d.st = q.sta ? S_WFREE : S_IDLE;
          endcase
        end
      end
      S_BYTE: begin
        if (adv) begin
          d.ph = q.ph + 2'd1;
          unique case (q.ph)
            2'd0: d.sda = (q.bitn == ACK_SLOT) ? 1'b0 : !q.sh[7];
            2'd1: d.scl = 1'b0;
            2'd2: begin
              if (q.bitn == ACK_SLOT) begin
                d.ack = !sda_in;
              end else if (!q.sda && !sda_in) begin
                d.st   = S_LOST;
                d.scl  = 1'b0;
                d.sda  = 1'b0;
                d.flag = 1'b1;
                d.stat = ST_ARB;
              end
            end
            2'd3: begin
              d.scl = 1'b1;
              if (q.bitn == ACK_SLOT) begin
                d.addr = 1'b0;
                if (q.rd) begin
                  d.st = S_RXH;
                end else begin
                  d.st   = S_HOLD;
                  d.flag = 1'b1;
                  if (q.addr) d.stat = q.ack ? ST_AW_ACK : ST_AW_NACK;
                  else        d.stat = q.ack ? ST_D_ACK  : ST_D_NACK;
                end
              end else begin
                d.bitn = q.bitn + 4'd1;
                d.sh   = {q.sh[6:0], 1'b0};
              end
            end
          endcase
        end
      end
      default: d.st = S_IDLE;
    endcase
    if (!en_q) begin
      d.st   = S_IDLE;
      d.scl  = 1'b0;
      d.sda  = 1'b0;
      d.flag = 1'b0;
      d.stat = ST_NONE;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      q      <= '0;
      q.stat <= ST_NONE;
    end else begin
      q <= d;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      en_q <= 1'b0;
    else if (ctl_wr) en_q <= ctl_en;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i)      dat_q <= '0;
    else if (dat_wr) dat_q <= dat_in;
  end

  assign scl_oe     = q.scl;
  assign sda_oe     = q.sda;
  assign status     = q.stat;
  assign flag       = q.flag;
  assign stop_pend  = q.sto;
  assign rx_handoff = (q.st == S_RXH);

endmodule

// File: rtl/i2cm_tx_master_chk.sv
module i2cm_tx_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic       scl_in,
  input logic       sda_in,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [7:0] status,
  input logic       flag,
  input logic       stop_pend,
  input logic       bus_busy,
  input logic       rx_handoff
);

  AST_CLEAR_FLAG_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> status == 8'hF8); // R5

  AST_FLAG_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && status != 8'h38) |-> scl_oe); // R5

  AST_FLAG_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (status == 8'h08 || status == 8'h10 || status == 8'h18 ||
                     status == 8'h20 || status == 8'h28 || status == 8'h30 ||
                     status == 8'h38)); // R2

  AST_LOST_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && status == 8'h38) |-> (!scl_oe && !sda_oe)); // R8

  AST_STOP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stop_pend) && !$past(ctl_wr)) |-> (!scl_oe && !sda_oe)); // R7

  AST_START_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_in && $past(scl_in) && $fell(sda_in)) |=> bus_busy); // R10

  AST_HANDOFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_handoff |-> (!flag && scl_oe)); // R11

endmodule

bind i2cm_tx_master i2cm_tx_master_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctl_wr     (ctl_wr),
  .scl_in     (scl_in),
  .sda_in     (sda_in),
  .scl_oe     (scl_oe),
  .sda_oe     (sda_oe),
  .status     (status),
  .flag       (flag),
  .stop_pend  (stop_pend),
  .bus_busy   (bus_busy),
  .rx_handoff (rx_handoff)
);

// File: tb/test_i2cm_tx_master.sv
module test_i2cm_tx_master;

  localparam int DIV = 3;

  logic       clk;
  logic       rst_n;
  logic       ctl_wr, ctl_en, ctl_sta, ctl_sto, ctl_go;
  logic       dat_wr;
  logic [7:0] dat_in;
  logic [7:0] div_cfg;
  logic       scl_oe, sda_oe, flag, stop_pend, bus_busy, rx_handoff;
  logic [7:0] status;
  logic       sda_drv;
  logic       ext_sda;
  logic       scl_line, sda_line;

  int nchk;
  int nfail;

  assign scl_line = !scl_oe;
  assign sda_line = !sda_oe && !sda_drv && !ext_sda;

  i2cm_tx_master #(.DIVW(8)) i_i2cm_tx_master (
    .clk (clk), .rst_n (rst_n),
    .ctl_wr (ctl_wr), .ctl_en (ctl_en), .ctl_sta (ctl_sta), .ctl_sto (ctl_sto),
    .ctl_go (ctl_go), .dat_wr (dat_wr), .dat_in (dat_in), .div_cfg (div_cfg),
    .scl_in (scl_line), .sda_in (sda_line), .scl_oe (scl_oe), .sda_oe (sda_oe),
    .status (status), .flag (flag), .stop_pend (stop_pend),
    .bus_busy (bus_busy), .rx_handoff (rx_handoff)
  );

  initial clk = 1'b0;
  always #4 clk = !clk;

  // slave-side bus model
  logic       prev_scl, prev_sda, ack_en;
  int         bits, arb_bit, high_cnt, last_high;
  logic [7:0] cap, last_byte;

  initial begin
    prev_scl = 1'b1; prev_sda = 1'b1; ack_en = 1'b0; sda_drv = 1'b0;
    bits = 0; arb_bit = -1; high_cnt = 0; last_high = 0; cap = 8'h00; last_byte = 8'h00;
  end

  always @(negedge clk) begin
    if (prev_scl && scl_line && prev_sda && !sda_line) bits = 0;
    if (!prev_scl && scl_line) begin
      if (bits == 8) begin
        bits = 0;
      end else begin
        cap  = {cap[6:0], sda_line};
        bits = bits + 1;
        if (bits == 8) last_byte = cap;
      end
    end
    if (prev_scl && !scl_line)
      sda_drv = (bits == 8 && ack_en) || (arb_bit >= 0 && bits == arb_bit);
    if (scl_line) high_cnt = high_cnt + 1;
    else if (prev_scl) begin last_high = high_cnt; high_cnt = 0; end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  // vector: {expected status, check-byte, slave ack, stop, start, byte}
  localparam logic [19:0] VEC [10] = '{
    {8'h08, 4'b0001, 8'h00},
    {8'h18, 4'b1100, 8'hA0},
    {8'h28, 4'b1100, 8'h5A},
    {8'h30, 4'b1000, 8'hC3},
    {8'h10, 4'b0001, 8'h00},
    {8'h20, 4'b1000, 8'h3C},
    {8'h08, 4'b0011, 8'h00},
    {8'h18, 4'b1100, 8'h42},
    {8'h28, 4'b1100, 8'h00},
    {8'h28, 4'b1100, 8'hFF}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic en, input logic sta, input logic sto, input logic go);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_en = en; ctl_sta = sta; ctl_sto = sto; ctl_go = go;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_go = 1'b0;
  endtask

  task automatic load(input logic [7:0] b);
    @(negedge clk);
    dat_wr = 1'b1; dat_in = b;
    @(negedge clk);
    dat_wr = 1'b0;
  endtask

  task automatic wait_flag(input string req);
    int n;
    n = 0;
    while (!flag && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (!flag) chk(req, 32'd0, 32'd1);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    nchk = 0; nfail = 0;
    ctl_wr = 0; ctl_en = 0; ctl_sta = 0; ctl_sto = 0; ctl_go = 0;
    dat_wr = 0; dat_in = 8'h00; div_cfg = 8'(DIV); ext_sda = 1'b0;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1 status", status, 8'hF8);
    chk("R1 flag", flag, 0);
    chk("R1 scl", scl_oe, 0);
    chk("R1 sda", sda_oe, 0);
    chk("R1 busy", bus_busy, 0);

    ctl(1'b1, 1'b0, 1'b0, 1'b0);
    // table walk: R2 R3 R4 R6
    for (int i = 0; i < 10; i++) begin
      logic [19:0] v;
      string req;
      v = VEC[i];
      ack_en = v[10];
      if (!v[8] && !v[9]) load(v[7:0]);
      ctl(1'b1, v[8], v[9], 1'b1);
      req = (v[19:12] == 8'h08 || v[19:12] == 8'h10) ? "R2" :
            (v[19:12] == 8'h18 || v[19:12] == 8'h20) ? "R3" : "R4";
      wait_flag(req);
      chk(req, status, v[19:12]);
      chk("R5 scl held", scl_oe, 1);
      if (v[11]) chk("R3 byte on wire", last_byte, v[7:0]);
      if (v[9]) chk("R6 stop+start done", stop_pend, 0);
    end
    chk("R12 scl high", last_high, 2 * (DIV + 1));

    // R7 stop
    ctl(1'b1, 1'b0, 1'b1, 1'b1);
    chk("R7 pending", stop_pend, 1);
    idle(100);
    chk("R7 cleared", stop_pend, 0);
    chk("R7 status", status, 8'hF8);
    chk("R7 flag", flag, 0);
    chk("R10 free after stop", bus_busy, 0);
    chk("R7 lines", {scl_oe, sda_oe}, 2'b00);

    // R11 read handoff
    ctl(1'b1, 1'b1, 1'b0, 1'b1);
    wait_flag("R2");
    chk("R2 start", status, 8'h08);
    ack_en = 1'b1;
    load(8'hA1);
    ctl(1'b1, 1'b0, 1'b0, 1'b1);
    idle(300);
    chk("R11 handoff", rx_handoff, 1);
    chk("R11 flag", flag, 0);
    chk("R11 status", status, 8'hF8);
    chk("R11 scl low", scl_oe, 1);
    ctl(1'b1, 1'b1, 1'b0, 1'b1);
    idle(60);
    chk("R11 start ignored", rx_handoff, 1);
    chk("R11 no flag", flag, 0);
    ctl(1'b1, 1'b0, 1'b1, 1'b1);
    idle(100);
    chk("R11 stop leaves", rx_handoff, 0);
    chk("R11 bus free", bus_busy, 0);

    // R8 / R9 arbitration, retry when free
    ctl(1'b1, 1'b1, 1'b0, 1'b1);
    wait_flag("R2");
    arb_bit = 2;
    load(8'hFE);
    ctl(1'b1, 1'b0, 1'b0, 1'b1);
    wait_flag("R8");
    chk("R8 status", status, 8'h38);
    chk("R8 lines", {scl_oe, sda_oe}, 2'b00);
    ctl(1'b1, 1'b1, 1'b0, 1'b1);
    idle(100);
    chk("R9 held off", flag, 0);
    chk("R9 still busy", bus_busy, 1);
    arb_bit = -1;
    sda_drv = 1'b0;
    wait_flag("R9");
    chk("R9 retry start", status, 8'h08);
    ctl(1'b1, 1'b0, 1'b1, 1'b1);
    idle(100);

    // R9 release path
    ctl(1'b1, 1'b1, 1'b0, 1'b1);
    wait_flag("R2");
    arb_bit = 2;
    load(8'hFE);
    ctl(1'b1, 1'b0, 1'b0, 1'b1);
    wait_flag("R8");
    chk("R8 status again", status, 8'h38);
    ctl(1'b1, 1'b0, 1'b0, 1'b1);
    idle(40);
    chk("R9 release flag", flag, 0);
    chk("R9 release status", status, 8'hF8);
    chk("R9 release lines", {scl_oe, sda_oe}, 2'b00);
    arb_bit = -1;
    sda_drv = 1'b0;
    idle(10);
    chk("R10 foreign stop", bus_busy, 0);

    // R10 foreign master START/STOP
    ext_sda = 1'b1;
    idle(3);
    chk("R10 foreign start", bus_busy, 1);
    ext_sda = 1'b0;
    idle(3);
    chk("R10 foreign stop2", bus_busy, 0);

    // R1 enable off mid-transfer
    ctl(1'b1, 1'b1, 1'b0, 1'b1);
    wait_flag("R2");
    ctl(1'b0, 1'b0, 1'b0, 1'b0);
    idle(3);
    chk("R1 disabled lines", {scl_oe, sda_oe}, 2'b00);
    chk("R1 disabled flag", flag, 0);
    chk("R1 disabled status", status, 8'hF8);

    summary();
    $finish;
  end

endmodule